// File: doc/BRIEF.md
# Delay-Line TDC Fine-Time Decoder

This block turns the sampled state of a tapped delay line into a fine arrival time for each channel of a multi-channel time-to-digital converter. Every bunch-crossing clock period, each channel presents a snapshot of 64 sampling flops. The flops are clocked from the taps of a locked delay line that spans exactly one period, so tap i samples the discriminator level at i/64 of the period (about 0.39 ns per tap at 25 ns). The decoder removes single-tap bubbles, finds the first low-to-high transition and reports a hit flag with a 6-bit fine time. A valid hit is reported only when the signal has a genuine leading edge in the current period.

A signal that was already high at the end of the previous period and is still high at tap 0 continues an earlier pulse. The decoder keeps one bit per channel, the filtered level of the last tap from the previous period, so that it can tell a continuation from an edge that lands exactly on the period boundary. A per-channel enable suppresses reporting from individual channels. Outputs are registered and show the result one clock after the snapshot is sampled.

Top module: `tdc_fine_decoder`

## Requirements
- R1: While rst_n is low, every bit of hit_out and fine_out is 0, whatever the tap inputs are.
- R2: The outputs change only on a rising clock edge and reflect the snapshot and enables sampled on that same edge, so a result is visible one clock after its snapshot is applied.
- R3: Channel c reads taps_in[c*64 +: 64], where bit i is tap i, and drives hit_out[c] and fine_out[c*6 +: 6]. When the filtered snapshot has a 0-to-1 step between tap i-1 and tap i (1 <= i <= 63), hit_out[c] is 1 and fine_out holds i.
- R4: Each interior tap (1 to 62) is replaced by the majority of itself and its two neighbours before the edge search. Taps 0 and 63 pass through unchanged. A single dropped bit inside a high run or a lone set bit inside a low run therefore neither moves nor creates an edge.
- R5: A channel whose snapshot is all zeros reports hit 0 and fine time 0.
- R6: If filtered tap 0 is 1 and filtered tap 63 of the previous period was 0, the edge lies on the boundary: hit is 1 and the fine time is 0.
- R7: If filtered tap 0 is 1 and filtered tap 63 of the previous period was 1, tap 0 is not an edge. With no later rise in the snapshot, no hit is reported. The first period after reset treats the previous tap 63 as 1.
- R8: When chan_en[c] is 0, hit_out[c] and the channel's fine time are 0. The channel still records its last tap, so a later boundary decision after re-enabling uses the masked period's level.
- R9: When the filtered snapshot has several rising steps, the lowest tap index is reported.
- R10: Channels decode independently. Different patterns and enables on different channels give each channel its own result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| taps_in | input | N_CH*N_TAP | Tap snapshots, channel c in slice c*N_TAP |
| chan_en | input | N_CH | Per-channel enable, 0 suppresses reporting |
| hit_out | output | N_CH | Registered leading-edge flag per channel |
| fine_out | output | N_CH*FT_W | Registered fine time, channel c in slice c*FT_W |

## Verification
The hardest situation to reach is the period boundary. Whether an all-high tap 0 counts as an edge depends on a state bit that is not visible at the ports and was set by the previous period. This includes periods in which the channel was masked and produced no output. The stimulus therefore walks an ordered table in which each vector deliberately sets up the last-tap level for the next one. It places all-ones snapshots after both low-ending and high-ending periods, and after a masked low period, and covers the cycle right after reset. Bubble cases place a single flipped bit inside a run and a lone bit at the endpoint tap 63, where no filtering applies.

// File: rtl/ftd_pkg.sv
package ftd_pkg;

   localparam int unsigned DEF_CHANNELS = 32;
   localparam int unsigned DEF_TAPS     = 64;

   // Two-of-three vote used by the bubble filter.
   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (b & c) | (a & c);
   endfunction

endpackage

// File: rtl/ftd_bubble_filter.sv
module ftd_bubble_filter
   import ftd_pkg::*;
#(
   parameter int N_TAP     = DEF_TAPS,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic [N_TAP-1:0] raw,
   output logic [N_TAP-1:0] clean
);

   generate
      if (FILTER_EN) begin : g_vote
         for (genvar i = 0; i < N_TAP; i++) begin : g_tap
            if (i == 0 || i == N_TAP-1) begin : g_end
               // End taps have only one neighbour: keep them as sampled.
               assign clean[i] = raw[i];
            end else begin : g_mid
               assign clean[i] = vote3(raw[i-1], raw[i], raw[i+1]);
            end
         end
      end else begin : g_pass
         assign clean = raw;
      end
   endgenerate

endmodule

// File: rtl/ftd_edge_find.sv
module ftd_edge_find #(
   parameter int N_TAP = 64,
   localparam int FT_W = $clog2(N_TAP)
) (
   input  logic [N_TAP-1:0] lvl,
   input  logic             prev_top,
   output logic             found,
   output logic [FT_W-1:0]  pos
);

   logic [N_TAP-1:0] rise;

   // A rise at tap 0 compares against the last tap of the previous period.
   assign rise[0] = lvl[0] & ~prev_top;
   generate
      for (genvar i = 1; i < N_TAP; i++) begin : g_rise
         assign rise[i] = lvl[i] & ~lvl[i-1];
      end
   endgenerate

   // Lowest index has priority: scan downward so the last write wins.
   always_comb begin
      found = 1'b0;
      pos   = '0;
      for (int i = N_TAP-1; i >= 0; i--) begin
         if (rise[i]) begin
            found = 1'b1;
            pos   = i[FT_W-1:0];
         end
      end
   end

endmodule

// File: rtl/ftd_channel.sv
module ftd_channel
   import ftd_pkg::*;
#(
   parameter int N_TAP     = DEF_TAPS,
   parameter bit FILTER_EN = 1'b1,
   localparam int FT_W     = $clog2(N_TAP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_TAP-1:0] taps,
   input  logic             en,
   output logic             hit,
   output logic [FT_W-1:0]  ftime
);

   logic [N_TAP-1:0] lvl;
   logic             prev_top_q;
   logic             found;
   logic [FT_W-1:0]  pos;

   ftd_bubble_filter #(.N_TAP(N_TAP), .FILTER_EN(FILTER_EN)) u_filt (
      .raw   (taps),
      .clean (lvl)
   );

   ftd_edge_find #(.N_TAP(N_TAP)) u_find (
      .lvl      (lvl),
      .prev_top (prev_top_q),
      .found    (found),
      .pos      (pos)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit        <= 1'b0;
         ftime      <= '0;
         prev_top_q <= 1'b1;   // first period after reset: assume continuation
      end else begin
         prev_top_q <= lvl[N_TAP-1];   // tracked even while masked
         hit        <= en & found;
         ftime      <= (en & found) ? pos : '0;
      end
   end

   // R8: a masked sample never yields a hit
   assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> !hit);

   // R5: a flat-low snapshot never yields a hit
   assert_flat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(taps == '0) |-> !hit);

   // R6/R7: a hit at tap 0 requires the previous period to have ended low
   assert_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ftime == '0) |-> !$past(prev_top_q));

   // R3: the encoder points at a real rising step
   assert_edge_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (lvl[pos] && ((pos == '0) ? !prev_top_q : !lvl[pos - 1'b1])));

endmodule

// File: rtl/tdc_fine_decoder.sv
module tdc_fine_decoder
   import ftd_pkg::*;
#(
   parameter int N_CH      = DEF_CHANNELS,
   parameter int N_TAP     = DEF_TAPS,
   parameter bit FILTER_EN = 1'b1,
   localparam int FT_W     = $clog2(N_TAP)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_CH*N_TAP-1:0] taps_in,
   input  logic [N_CH-1:0]       chan_en,
   output logic [N_CH-1:0]       hit_out,
   output logic [N_CH*FT_W-1:0]  fine_out
);

   generate
      if (N_TAP < 4)               begin : g_bad_taps  $error("N_TAP must be at least 4"); end
      if ((1 << FT_W) != N_TAP)    begin : g_bad_pow2  $error("N_TAP must be a power of two"); end
      if (N_CH < 1)                begin : g_bad_ch    $error("N_CH must be at least 1"); end

      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         ftd_channel #(.N_TAP(N_TAP), .FILTER_EN(FILTER_EN)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .taps  (taps_in[c*N_TAP +: N_TAP]),
            .en    (chan_en[c]),
            .hit   (hit_out[c]),
            .ftime (fine_out[c*FT_W +: FT_W])
         );
      end
   endgenerate

endmodule

// File: tb/sim_tdc_fine_decoder.sv
`timescale 1ns/1ps
module sim_tdc_fine_decoder;

   localparam int NC = 32;
   localparam int NT = 64;
   localparam int FW = 6;
   localparam int NV = 15;
   localparam logic [63:0] ONES = {64{1'b1}};

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NC*NT-1:0]   taps_in = '0;
   logic [NC-1:0]      chan_en = '0;
   logic [NC-1:0]      hit_out;
   logic [NC*FW-1:0]   fine_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   tdc_fine_decoder u0 (
      .clk(clk), .rst_n(rst_n), .taps_in(taps_in), .chan_en(chan_en),
      .hit_out(hit_out), .fine_out(fine_out)
   );

   always #2.5 clk = ~clk;

   // Ordered vectors: each one sets the tap-63 history for the next.
   localparam logic [63:0] VP [NV] = '{
      64'd0,                                           // 0  R5 flat low
      ONES << 10,                                      // 1  R3 edge at 10
      ONES << 40,                                      // 2  R3 edge at 40
      ONES,                                            // 3  R7 continuation
      64'd0,                                           // 4  R5
      ONES,                                            // 5  R6 boundary edge
      (ONES << 20) & ~(64'd1 << 30),                   // 6  R4 hole in high run
      64'd1 << 7,                                      // 7  R4 lone bit removed
      64'd1 << 63,                                     // 8  R4 end tap unfiltered
      ((ONES << 5) & ~(ONES << 10)) | (ONES << 30),    // 9  R9 lowest wins
      ONES << 12,                                      // 10 R8 masked
      64'd0,                                           // 11 R8 masked, ends low
      ONES,                                            // 12 R8 history kept
      ONES << 1,                                       // 13 R3 edge at 1
      64'd1                                            // 14 R7 tap0 only, prev high
   };
   localparam bit VE [NV] = '{1,1,1,1,1,1,1,1,1,1,0,0,1,1,1};
   localparam bit VH [NV] = '{0,1,1,0,0,1,1,0,1,1,0,0,1,1,0};
   localparam int VF [NV] = '{0,10,40,0,0,0,20,0,63,5,0,0,0,1,0};
   localparam int VR [NV] = '{5,3,3,7,5,6,4,4,4,9,8,8,8,3,7};

   task automatic check(input int req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL R%0d actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_all(input int req, input bit eh, input int ef);
      check(req, longint'(hit_out), eh ? longint'({NC{1'b1}}) : 0);
      for (int c = 0; c < NC; c++)
         if (fine_out[c*FW +: FW] != FW'(ef)) begin
            check(req, longint'(fine_out[c*FW +: FW]), longint'(ef));
            return;
         end
      check(req, longint'(ef), longint'(ef));
   endtask

   initial begin
      // R1: outputs stay cleared under reset despite busy inputs
      taps_in = {NC{ONES << 3}};
      chan_en = '1;
      repeat (3) @(posedge clk);
      #1 check(1, longint'(hit_out), 0);
      check(1, longint'(fine_out != '0), 0);

      // R7: first period after reset treats history as high
      @(negedge clk);
      taps_in = {NC{ONES}};
      rst_n = 1'b1;
      @(posedge clk); #1;
      check_all(7, 1'b0, 0);

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         taps_in = {NC{VP[v]}};
         chan_en = {NC{VE[v]}};
         @(posedge clk); #1;
         check_all(VR[v], VH[v], VF[v]);
      end

      // R2: result appears only after the next rising edge
      @(negedge clk);
      taps_in = {NC{ONES << 10}};
      chan_en = '1;
      #1 check(2, longint'(hit_out), 0);
      @(posedge clk); #1;
      check_all(2, 1'b1, 10);

      // R10: distinct patterns per channel, odd channels masked
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
         taps_in[c*NT +: NT] = ONES << (c + 1);
         chan_en[c] = (c % 2 == 0);
      end
      @(posedge clk); #1;
      for (int c = 0; c < NC; c++) begin
         check(10, longint'(hit_out[c]), (c % 2 == 0) ? 1 : 0);
         check(10, longint'(fine_out[c*FW +: FW]), (c % 2 == 0) ? c + 1 : 0);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule